// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This unit serves the two register reads a virtual CPU uses to take a pending virtual interrupt whose source is a message-based interrupt (vLPI): the acknowledge read and the peek at the highest-pending ID. An external selector has already decided whether the vLPI beats every list-register candidate. When it has, the unit answers the read with the vLPI ID or with the spurious ID (1023), depending on the read type, the group that was asked for and a preemption test.

A successful acknowledge has two side effects. It marks the vLPI's group priority as active in a per-group bank of active-priority bits, held as four 32-bit words per group. It also sends a one-cycle pulse that carries the ID, so the pending state can be dropped elsewhere. The preemption test uses the running priority, and the unit works that out from its own active-priority bits. A debug port reads back any active-priority word.

Top module: `vlpi_ack_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `rsp_valid` and `clr_pulse` are 0, `rsp_id` and `clr_id` are 0, and all eight active-priority words read 0.
- R2: A read accepted on a rising edge (`rd_valid`=1) gives `rsp_valid`=1 for exactly the following cycle. When no read is accepted, `rsp_valid`=0 and `rsp_id`=0.
- R3: An acknowledge (`rd_ack`=1) returns `vlpi_id` only when `sel_vlpi`=1, `vlpi_grp` equals `rd_grp` and the preemption test passes. Otherwise it returns 1023.
- R4: A highest-pending read (`rd_ack`=0) returns `vlpi_id` when `sel_vlpi`=1 and the groups match, whatever the preemption test says. Otherwise it returns 1023. It changes no active-priority bit and raises no clear pulse.
- R5: The preemption test fails when `vif_en`=0 or when `vlpi_prio` >= `vpmr`.
- R6: With no active-priority bit set in either group, the preemption test passes when R5 does not block it. Otherwise the running priority is ((lowest set bit index k over both groups, a 128-bit view with bit 0 of word 0 lowest) << (8 - pb)) truncated to 8 bits, and the test passes only if (`vlpi_prio` & `gprio_mask`) < (running priority & `gprio_mask`).
- R7: A successful acknowledge sets bit index i = (`vlpi_prio` & `gprio_mask`) >> (8 - pb) in the bank of group `vlpi_grp`, at word i/32, bit i%32. The result is visible in the following cycle.
- R8: Active-priority bits are only ever set, never cleared, until reset. Each acknowledge adds to the bits already set.
- R9: A successful acknowledge raises `clr_pulse` for one cycle in the following cycle, with `clr_id` equal to the acknowledged ID. In every other cycle `clr_pulse`=0 and `clr_id`=0.
- R10: The effective priority-bit count pb is `prio_bits` clamped to the range 5 to 7. Any value below 5 acts as 5.
- R11: `dbg_apr` shows, combinationally, word `dbg_word` of the bank of group `dbg_grp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request strobe |
| rd_ack | input | 1 | 1 = acknowledge read, 0 = highest-pending read |
| rd_grp | input | 1 | Group requested (0 or 1) |
| sel_vlpi | input | 1 | Selector reports the vLPI as highest pending |
| vlpi_id | input | ID_W | vLPI interrupt ID |
| vlpi_grp | input | 1 | vLPI group |
| vlpi_prio | input | 8 | vLPI priority |
| gprio_mask | input | 8 | Group-priority mask for the vLPI's group |
| prio_bits | input | 3 | Implemented priority bits |
| vif_en | input | 1 | Virtual interface enable |
| vpmr | input | 8 | Virtual priority mask |
| dbg_grp | input | 1 | Debug group select |
| dbg_word | input | 2 | Debug word select |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | ID_W | Returned ID |
| clr_pulse | output | 1 | Pending-clear pulse |
| clr_id | output | ID_W | ID to clear |
| dbg_apr | output | 32 | Selected active-priority word |

## Verification
The in-module assertions check several rules on every cycle. A clear pulse always comes with a response that carries the same ID. Active-priority bits never drop. Those bits change only after an acknowledge that qualified. A response that comes from an unselected vLPI is always spurious. The exact bit index, the running-priority comparison, the clamping of the priority-bit count and the cumulative state over many acknowledges can only be shown by the bench. Its behavioural model is compared with every output and every debug word on every clock, across directed and random sequences.

// File: rtl/vlpi_ack_unit.sv
module vlpi_ack_unit #(
  parameter int ID_W    = 16,
  parameter int SPUR_ID = 1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_valid,
  input  logic            rd_ack,
  input  logic            rd_grp,
  input  logic            sel_vlpi,
  input  logic [ID_W-1:0] vlpi_id,
  input  logic            vlpi_grp,
  input  logic [7:0]      vlpi_prio,
  input  logic [7:0]      gprio_mask,
  input  logic [2:0]      prio_bits,
  input  logic            vif_en,
  input  logic [7:0]      vpmr,
  input  logic            dbg_grp,
  input  logic [1:0]      dbg_word,
  output logic            rsp_valid,
  output logic [ID_W-1:0] rsp_id,
  output logic            clr_pulse,
  output logic [ID_W-1:0] clr_id,
  output logic [31:0]     dbg_apr
);
  localparam int MAXPB    = 7;
  localparam int MINPB    = 5;
  localparam int APR_BITS = 1 << MAXPB;
  localparam int IW       = MAXPB;

  logic [APR_BITS-1:0] apr_q [2];

  logic [2:0] pb_eff;
  logic [1:0] shamt;
  logic [7:0] masked;
  logic [7:0] idx_w;
  logic [IW-1:0] bit_idx;
  logic [APR_BITS-1:0] act_all;
  logic [IW-1:0] low_idx;
  logic any_act;
  logic [9:0] rp_w;
  logic [7:0] rprio;
  logic preempt, grp_ok, ack_ok, hp_ok;

  assign pb_eff  = (prio_bits < 3'(MINPB)) ? 3'(MINPB) : prio_bits;
  assign shamt   = 2'(4'd8 - {1'b0, pb_eff});
  assign masked  = vlpi_prio & gprio_mask;
  assign idx_w   = masked >> shamt;
  assign bit_idx = idx_w[IW-1:0];
  assign act_all = apr_q[0] | apr_q[1];
  assign any_act = |act_all;

  always_comb begin
    low_idx = '0;
    for (int i = APR_BITS - 1; i >= 0; i--)
      if (act_all[i]) low_idx = IW'(i);
  end

  assign rp_w  = {3'b000, low_idx} << shamt;
  assign rprio = any_act ? rp_w[7:0] : 8'hFF;

  assign preempt = vif_en && (vlpi_prio < vpmr) &&
                   (!any_act || (masked < (rprio & gprio_mask)));
  assign grp_ok  = (vlpi_grp == rd_grp);
  assign ack_ok  = rd_valid && rd_ack && sel_vlpi && grp_ok && preempt;
  assign hp_ok   = rd_valid && !rd_ack && sel_vlpi && grp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      clr_pulse <= 1'b0;
      clr_id    <= '0;
      apr_q[0]  <= '0;
      apr_q[1]  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      rsp_id    <= !rd_valid ? '0 : ((ack_ok || hp_ok) ? vlpi_id : ID_W'(SPUR_ID));
      clr_pulse <= ack_ok;
      clr_id    <= ack_ok ? vlpi_id : '0;
      if (ack_ok) apr_q[vlpi_grp][bit_idx] <= 1'b1;
    end
  end

  assign dbg_apr = apr_q[dbg_grp][{dbg_word, 5'b00000} +: 32];

  AST_CLR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> (rsp_valid && rsp_id == clr_id)); // R9

  AST_APR_STICKY0: assert property (@(posedge clk) disable iff (!rst_n)
    (apr_q[0] & $past(apr_q[0])) == $past(apr_q[0])); // R8

  AST_APR_STICKY1: assert property (@(posedge clk) disable iff (!rst_n)
    (apr_q[1] & $past(apr_q[1])) == $past(apr_q[1])); // R8

  AST_APR_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_ok) |-> ($stable(apr_q[0]) && $stable(apr_q[1]))); // R4

  AST_SPUR_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(sel_vlpi)) |-> rsp_id == ID_W'(SPUR_ID)); // R3

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid)); // R2

  AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(rd_ack && sel_vlpi && vif_en)); // R9
endmodule

// File: tb/tb_vlpi_ack_unit.sv
`timescale 1ns/100ps
module tb_vlpi_ack_unit;
  localparam real CLK_PERIOD = 10.0;
  localparam int  SPUR = 1023;

  logic clk = 0, rst_n = 0;
  logic rd_valid = 0, rd_ack = 0, rd_grp = 0, sel_vlpi = 0;
  logic [15:0] vlpi_id = 0;
  logic vlpi_grp = 0;
  logic [7:0] vlpi_prio = 0, gprio_mask = 0, vpmr = 0;
  logic [2:0] prio_bits = 0;
  logic vif_en = 0, dbg_grp = 0;
  logic [1:0] dbg_word = 0;
  logic rsp_valid, clr_pulse;
  logic [15:0] rsp_id, clr_id;
  logic [31:0] dbg_apr;

  int checks = 0, failures = 0, cycles = 0;
  bit [31:0] apr_m [2][4];

  vlpi_ack_unit dut (.clk, .rst_n, .rd_valid, .rd_ack, .rd_grp, .sel_vlpi,
    .vlpi_id, .vlpi_grp, .vlpi_prio, .gprio_mask, .prio_bits, .vif_en, .vpmr,
    .dbg_grp, .dbg_word, .rsp_valid, .rsp_id, .clr_pulse, .clr_id, .dbg_apr);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_words(string tag);
    for (int g = 0; g < 2; g++)
      for (int w = 0; w < 4; w++) begin
        dbg_grp = 1'(g); dbg_word = 2'(w);
        #0.5;
        chk(tag, $sformatf("apr[%0d][%0d]", g, w), int'(dbg_apr), int'(apr_m[g][w]));
      end
  endtask

  task automatic do_reset();
    rst_n = 0; rd_valid = 0;
    for (int i = 0; i < 4; i++) apr_m[i/2][i%2] = 0;
    for (int g = 0; g < 2; g++) for (int w = 0; w < 4; w++) apr_m[g][w] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1", "clr_pulse in reset", int'(clr_pulse), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "rsp_id", int'(rsp_id), 0);
    chk("R1", "clr_pulse", int'(clr_pulse), 0);
    chk("R1", "clr_id", int'(clr_id), 0);
    chk_words("R1");
  endtask

  task automatic step(bit v, bit ack, bit g, bit sel, int id, bit vg, int pr,
                      int gm, int pb, bit en, int pm, string tag);
    int pbe, sh, masked, idx, low, rp, e_id;
    bit found, pre, ack_ok, hp_ok;
    rd_valid = v; rd_ack = ack; rd_grp = g; sel_vlpi = sel; vlpi_id = 16'(id);
    vlpi_grp = vg; vlpi_prio = 8'(pr); gprio_mask = 8'(gm); prio_bits = 3'(pb);
    vif_en = en; vpmr = 8'(pm);
    pbe = (pb < 5) ? 5 : pb;
    sh = 8 - pbe;
    masked = pr & gm;
    idx = masked >> sh;
    found = 0; low = 0;
    for (int k = 0; k < 128 && !found; k++)
      if (apr_m[0][k/32][k%32] || apr_m[1][k/32][k%32]) begin found = 1; low = k; end
    rp = found ? ((low << sh) & 255) : 255;
    pre = en && (pr < pm) && (!found || masked < (rp & gm));
    ack_ok = v && ack && sel && (g == vg) && pre;
    hp_ok = v && !ack && sel && (g == vg);
    e_id = !v ? 0 : ((ack_ok || hp_ok) ? id : SPUR);
    if (ack_ok) apr_m[vg][idx/32][idx%32] = 1'b1;
    @(posedge clk); #1;
    chk(tag, "rsp_valid", int'(rsp_valid), int'(v));
    chk(tag, "rsp_id", int'(rsp_id), e_id);
    chk(tag, "clr_pulse", int'(clr_pulse), int'(ack_ok));
    chk(tag, "clr_id", int'(clr_id), ack_ok ? id : 0);
    chk_words(tag);
  endtask

  initial begin
    do_reset();
    // R4: highest-pending read, match / mismatch / unselected; no side effects
    step(1, 0, 1, 1, 77, 1, 8'h40, 8'hF8, 5, 0, 8'h00, "R4");
    step(1, 0, 0, 1, 77, 1, 8'h40, 8'hF8, 5, 1, 8'hFF, "R4");
    step(1, 0, 1, 0, 77, 1, 8'h40, 8'hF8, 5, 1, 8'hFF, "R4");
    // R2: idle cycle
    step(0, 1, 1, 1, 77, 1, 8'h40, 8'hF8, 5, 1, 8'hFF, "R2");
    // R5: interface disabled, priority masked
    step(1, 1, 1, 1, 88, 1, 8'h40, 8'hF8, 5, 0, 8'hFF, "R5");
    step(1, 1, 1, 1, 88, 1, 8'h40, 8'hF8, 5, 1, 8'h40, "R5");
    // R3: group mismatch on acknowledge
    step(1, 1, 0, 1, 88, 1, 8'h40, 8'hF8, 5, 1, 8'hFF, "R3");
    // R7 / R9: successful acknowledge, idx 8 in group 1 word 0
    step(1, 1, 1, 1, 300, 1, 8'h40, 8'hF8, 5, 1, 8'hFF, "R7");
    // R6: 0x20 beats running 0x40, then 0x30 cannot beat 0x20
    step(1, 1, 0, 1, 301, 0, 8'h20, 8'hF8, 5, 1, 8'hFF, "R6");
    step(1, 1, 0, 1, 302, 0, 8'h30, 8'hF8, 5, 1, 8'hFF, "R6");
    // R8: pending read after acks leaves bits alone; back-to-back acks accumulate
    step(1, 0, 0, 1, 303, 0, 8'h08, 8'hF8, 5, 1, 8'hFF, "R8");
    step(1, 1, 0, 1, 304, 0, 8'h08, 8'hF8, 5, 1, 8'hFF, "R8");
    step(1, 1, 1, 1, 305, 1, 8'h00, 8'hF8, 5, 1, 8'hFF, "R8");
    do_reset();
    // R7: top bit index 127 with 7 priority bits, group 0 word 3 bit 31
    step(1, 1, 0, 1, 500, 0, 8'hFE, 8'hFE, 7, 1, 8'hFF, "R7");
    do_reset();
    // R10: prio_bits 2 acts as 5 (idx 0x48>>3 = 9)
    step(1, 1, 1, 1, 600, 1, 8'h48, 8'hFF, 2, 1, 8'hFF, "R10");
    step(1, 1, 1, 1, 601, 1, 8'h20, 8'hFF, 0, 1, 8'hFF, "R10");
    // R11 plus all others: random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int masks [4] = '{8'hF8, 8'hFC, 8'hFE, 8'hFF};
      bit g = 1'($urandom);
      if (n % 80 == 79) do_reset();
      step(($urandom % 8) != 0, 1'($urandom), g, ($urandom % 4) != 0,
           int'($urandom % 1024), ($urandom % 10 < 7) ? g : ~g,
           int'($urandom % 256), masks[$urandom % 4], int'($urandom % 8),
           ($urandom % 16) != 0, ($urandom % 4 == 0) ? int'($urandom % 256) : 255,
           "R11");
    end
    finish_run();
  end
endmodule